// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Array

This block holds up to four waiting instructions in front of a single functional unit. An issue stage hands it an opcode and two source operands. Each operand is either a finished 32-bit value or the tag of the station that will produce it. The block places the instruction in the lowest-numbered free slot and reports that slot's own tag back to the issue stage, so the renaming logic can record it as the destination. When every slot is taken, it raises a stall.

Slots with a pending operand watch the shared result bus. When the tag on the bus matches, the slot copies the data in. An operand whose producer broadcasts in the same cycle as the issue is captured on that issue, so the wakeup is not lost. Once both operands hold values, the slot is eligible for the functional unit. Among the eligible slots, the one issued earliest wins, judged by a per-slot issue sequence number. Instructions can therefore leave in a different order from the one in which they arrived. The slot stays occupied after dispatch and is released when the result bus carries its own tag.

Each slot runs a four-state machine:
- FREE goes to WAIT or READY on allocation. It goes to READY when both operands are values after the capture on the issue cycle.
- WAIT goes to READY on the cycle its last pending operand is captured.
- READY goes to EXEC on a handshake with the unit.
- EXEC goes back to FREE when the bus broadcasts the slot's tag.

Top module: `rs_array`

## Requirements
- R1: After reset every slot is free: `issue_stall` is 0 and `fu_valid` is 0.
- R2: An issue with `issue_valid`=1 and `issue_stall`=0 is accepted at the clock edge. It goes to the lowest-indexed free slot. `issue_tag` shows that slot's tag combinationally in the same cycle.
- R3: `issue_stall` is 1 exactly when all four slots are occupied. An issue attempted while stalled is dropped and leaves no instruction behind.
- R4: A slot waiting on an operand copies `cdb_data` into it when `cdb_valid`=1 and `cdb_tag` equals that operand's tag. A broadcast with any other tag leaves the operand pending.
- R5: If an issued operand's tag is on the bus in the issue cycle, the value is captured with the issue. The instruction becomes eligible in the next cycle.
- R6: A slot is offered to the unit (`fu_valid`=1) only when both its operands hold values. This happens from the cycle after the edge that made the last one a value.
- R7: When several slots are eligible, the one issued earliest is offered, whatever its slot index. This may be later than the order of issue relative to slots still waiting.
- R8: An offer completes on a cycle with `fu_valid`=1 and `fu_ready`=1, and that slot is never offered again. While `fu_ready`=0 and no older slot becomes eligible, the same offer is held.
- R9: A dispatched slot stays occupied until the bus broadcasts its own tag with `cdb_valid`=1. It is free from the next cycle, and `issue_stall` drops then if it was high.
- R10: A slot's tag is `{UNIT_ID, slot index}`: 4 bits, with unit ID 1 giving tags 4 to 7. `fu_tag` carries it, and `fu_op`/`fu_a`/`fu_b` carry the slot's opcode and captured operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request present |
| issue_op | input | 4 | Opcode to hold |
| issue_a_real | input | 1 | Operand A is a value (1) or a tag (0) |
| issue_a_val | input | 32 | Operand A value |
| issue_a_tag | input | 4 | Operand A producer tag |
| issue_b_real | input | 1 | Operand B is a value (1) or a tag (0) |
| issue_b_val | input | 32 | Operand B value |
| issue_b_tag | input | 4 | Operand B producer tag |
| issue_stall | output | 1 | All slots occupied; issue not accepted |
| issue_tag | output | 4 | Tag of the slot an issue this cycle would take |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 4 | Tag of the broadcast producer |
| cdb_data | input | 32 | Broadcast result value |
| fu_valid | output | 1 | An eligible instruction is offered |
| fu_ready | input | 1 | Functional unit accepts the offer |
| fu_op | output | 4 | Offered opcode |
| fu_a | output | 32 | Offered operand A |
| fu_b | output | 32 | Offered operand B |
| fu_tag | output | 4 | Tag of the offered slot |

## Verification
A slot stuck in WAIT after its tag was broadcast shows up as a missing dispatch. The scoreboard still holds an expected entry when the run ends. A wrongly captured value or a bad age choice shows at the very next handshake, as a mismatched `fu_tag` or operand. A slot that fails to return to FREE keeps `issue_stall` high one cycle after its tag's broadcast, where the bench samples it. A slot that never leaves READY offers the same tag again on the cycle after its handshake.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_EXEC  = 2'd3
    } slot_state_e;

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int SEQ_W  = 3,
    parameter logic [TAG_W-1:0] MY_TAG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [OP_W-1:0]   in_op,
    input  logic              in_a_real,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_real,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op_q,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic [SEQ_W-1:0]  seq_q
);

    slot_state_e state_q, state_d;

    logic              a_real_q, b_real_q, a_real_d, b_real_d;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q, a_tag_d, b_tag_d;
    logic [DATA_W-1:0] a_d, b_d;
    logic [OP_W-1:0]   op_d;
    logic [SEQ_W-1:0]  seq_d;
    logic              bus_self;

    assign bus_self = cdb_valid && (cdb_tag == MY_TAG);

    // Operand capture: on issue (including same-cycle wakeup) or while waiting.
    always_comb begin
        a_real_d = a_real_q;
        b_real_d = b_real_q;
        a_tag_d  = a_tag_q;
        b_tag_d  = b_tag_q;
        a_d      = a_q;
        b_d      = b_q;
        op_d     = op_q;
        seq_d    = seq_q;
        if (alloc) begin
            op_d     = in_op;
            seq_d    = in_seq;
            a_real_d = in_a_real;
            a_d      = in_a_val;
            a_tag_d  = in_a_tag;
            b_real_d = in_b_real;
            b_d      = in_b_val;
            b_tag_d  = in_b_tag;
            if (!in_a_real && cdb_valid && (cdb_tag == in_a_tag)) begin
                a_real_d = 1'b1;
                a_d      = cdb_data;
            end
            if (!in_b_real && cdb_valid && (cdb_tag == in_b_tag)) begin
                b_real_d = 1'b1;
                b_d      = cdb_data;
            end
        end else if (state_q == SLOT_WAIT) begin
            if (!a_real_q && cdb_valid && (cdb_tag == a_tag_q)) begin
                a_real_d = 1'b1;
                a_d      = cdb_data;
            end
            if (!b_real_q && cdb_valid && (cdb_tag == b_tag_q)) begin
                b_real_d = 1'b1;
                b_d      = cdb_data;
            end
        end
    end

    // Next-state logic of the slot machine.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE:  if (alloc)
                            state_d = (a_real_d && b_real_d) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (a_real_d && b_real_d) state_d = SLOT_READY;
            SLOT_READY: if (grant)    state_d = SLOT_EXEC;
            SLOT_EXEC:  if (bus_self) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // Payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_real_q <= 1'b0;
            b_real_q <= 1'b0;
            a_tag_q  <= '0;
            b_tag_q  <= '0;
            a_q      <= '0;
            b_q      <= '0;
            op_q     <= '0;
            seq_q    <= '0;
        end else begin
            a_real_q <= a_real_d;
            b_real_q <= b_real_d;
            a_tag_q  <= a_tag_d;
            b_tag_q  <= b_tag_d;
            a_q      <= a_d;
            b_q      <= b_d;
            op_q     <= op_d;
            seq_q    <= seq_d;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        busy  = (state_q != SLOT_FREE);
        ready = (state_q == SLOT_READY);
    end

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_SLOTS-1:0] busy,
    output logic               full,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        full = 1'b1;
        idx  = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                full = 1'b0;
                idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2,
    parameter int SEQ_W   = 3
) (
    input  logic [N_SLOTS-1:0]            ready,
    input  logic [N_SLOTS-1:0][SEQ_W-1:0] seq,
    output logic [N_SLOTS-1:0]            sel,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    function automatic logic is_older(input logic [SEQ_W-1:0] x,
                                      input logic [SEQ_W-1:0] y);
        logic [SEQ_W-1:0] diff;
        diff = x - y;
        return diff[SEQ_W-1];
    endfunction

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_win
        logic win;
        always_comb begin
            win = ready[i];
            for (int j = 0; j < N_SLOTS; j++) begin
                if (j != i && ready[j] && is_older(seq[j], seq[i]))
                    win = 1'b0;
            end
        end
        assign sel[i] = win;
    end

    always_comb begin
        any = |ready;
        idx = '0;
        for (int i = 0; i < N_SLOTS; i++)
            if (sel[i]) idx = IDX_W'(i);
    end

endmodule

// File: rtl/rs_array.sv
module rs_array #(
    parameter int N_SLOTS = 4,
    parameter int UNIT_W  = 2,
    parameter int UNIT_ID = 1,
    parameter int OP_W    = 4,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(N_SLOTS),
    localparam int TAG_W  = UNIT_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic              issue_a_real,
    input  logic [DATA_W-1:0] issue_a_val,
    input  logic [TAG_W-1:0]  issue_a_tag,
    input  logic              issue_b_real,
    input  logic [DATA_W-1:0] issue_b_val,
    input  logic [TAG_W-1:0]  issue_b_tag,
    output logic              issue_stall,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              fu_valid,
    input  logic              fu_ready,
    output logic [OP_W-1:0]   fu_op,
    output logic [DATA_W-1:0] fu_a,
    output logic [DATA_W-1:0] fu_b,
    output logic [TAG_W-1:0]  fu_tag
);

    localparam int SEQ_W = IDX_W + 1;
    localparam logic [UNIT_W-1:0] UNIT_CODE = UNIT_W'(UNIT_ID);

    logic [N_SLOTS-1:0]            slot_busy, slot_ready, grant_vec, alloc_vec;
    logic [N_SLOTS-1:0][SEQ_W-1:0] slot_seq;
    logic [OP_W-1:0]               slot_op [N_SLOTS];
    logic [DATA_W-1:0]             slot_a  [N_SLOTS];
    logic [DATA_W-1:0]             slot_b  [N_SLOTS];
    logic [IDX_W-1:0]              alloc_idx, pick_idx;
    logic                          full, issue_fire, pick_any;
    logic [SEQ_W-1:0]              seq_ctr;

    rs_alloc #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_alloc (
        .busy (slot_busy),
        .full (full),
        .idx  (alloc_idx)
    );

    assign issue_stall = full;
    assign issue_tag   = {UNIT_CODE, alloc_idx};
    assign issue_fire  = issue_valid && !full;

    always_ff @(posedge clk) begin
        if (!rst_n)          seq_ctr <= '0;
        else if (issue_fire) seq_ctr <= seq_ctr + 1'b1;
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        localparam logic [TAG_W-1:0] SLOT_TAG = {UNIT_CODE, IDX_W'(i)};

        assign alloc_vec[i] = issue_fire && (alloc_idx == IDX_W'(i));

        rs_slot #(
            .OP_W   (OP_W),
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .SEQ_W  (SEQ_W),
            .MY_TAG (SLOT_TAG)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[i]),
            .in_op     (issue_op),
            .in_a_real (issue_a_real),
            .in_a_val  (issue_a_val),
            .in_a_tag  (issue_a_tag),
            .in_b_real (issue_b_real),
            .in_b_val  (issue_b_val),
            .in_b_tag  (issue_b_tag),
            .in_seq    (seq_ctr),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_data  (cdb_data),
            .grant     (grant_vec[i] && fu_ready),
            .busy      (slot_busy[i]),
            .ready     (slot_ready[i]),
            .op_q      (slot_op[i]),
            .a_q       (slot_a[i]),
            .b_q       (slot_b[i]),
            .seq_q     (slot_seq[i])
        );
    end

    rs_pick #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_pick (
        .ready (slot_ready),
        .seq   (slot_seq),
        .sel   (grant_vec),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb begin
        fu_valid = pick_any;
        fu_tag   = {UNIT_CODE, pick_idx};
        fu_op    = '0;
        fu_a     = '0;
        fu_b     = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (grant_vec[i]) begin
                fu_op = slot_op[i];
                fu_a  = slot_a[i];
                fu_b  = slot_b[i];
            end
        end
    end

endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2,
    parameter int TAG_W   = 4,
    parameter int UNIT_W  = 2,
    parameter int UNIT_ID = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               issue_valid,
    input logic               issue_stall,
    input logic [TAG_W-1:0]   issue_tag,
    input logic               fu_valid,
    input logic               fu_ready,
    input logic [TAG_W-1:0]   fu_tag,
    input logic [N_SLOTS-1:0] occ_vec,
    input logic [N_SLOTS-1:0] grant_vec
);

    // R1: an empty array neither stalls nor offers work
    assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_vec == '0) |-> (!fu_valid && !issue_stall));

    // R2: an accepted issue occupies the slot it advertised
    assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_stall) |=> occ_vec[$past(issue_tag[IDX_W-1:0])]);

    // R3: a stalled issue adds no occupant
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_stall) |=>
            ($countones(occ_vec) <= $countones($past(occ_vec))));

    // R6: an offer always comes from an occupied slot
    assert_offer_occupied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |-> occ_vec[fu_tag[IDX_W-1:0]]);

    // R7: at most one slot selected
    assert_single_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    // R8: a completed offer is not repeated
    assert_no_redispatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_valid && fu_ready) |=> !(fu_valid && (fu_tag == $past(fu_tag))));

    // R10: offered tag carries this unit's ID
    assert_unit_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fu_valid |-> (fu_tag[TAG_W-1:IDX_W] == UNIT_W'(UNIT_ID)));

endmodule

bind rs_array rs_array_chk #(
    .N_SLOTS (N_SLOTS),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W),
    .UNIT_W  (UNIT_W),
    .UNIT_ID (UNIT_ID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_stall (issue_stall),
    .issue_tag   (issue_tag),
    .fu_valid    (fu_valid),
    .fu_ready    (fu_ready),
    .fu_tag      (fu_tag),
    .occ_vec     (slot_busy),
    .grant_vec   (grant_vec)
);

// File: tb/rs_array_test.sv
module rs_array_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  issue_op = '0;
    logic        issue_a_real = 1'b0, issue_b_real = 1'b0;
    logic [31:0] issue_a_val = '0, issue_b_val = '0;
    logic [3:0]  issue_a_tag = '0, issue_b_tag = '0;
    logic        issue_stall;
    logic [3:0]  issue_tag;
    logic        cdb_valid = 1'b0;
    logic [3:0]  cdb_tag = '0;
    logic [31:0] cdb_data = '0;
    logic        fu_valid;
    logic        fu_ready = 1'b0;
    logic [3:0]  fu_op;
    logic [31:0] fu_a, fu_b;
    logic [3:0]  fu_tag;

    always #5 clk = ~clk;

    rs_array uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a_real(issue_a_real), .issue_a_val(issue_a_val), .issue_a_tag(issue_a_tag),
        .issue_b_real(issue_b_real), .issue_b_val(issue_b_val), .issue_b_tag(issue_b_tag),
        .issue_stall(issue_stall), .issue_tag(issue_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .fu_valid(fu_valid), .fu_ready(fu_ready), .fu_op(fu_op),
        .fu_a(fu_a), .fu_b(fu_b), .fu_tag(fu_tag)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
    } disp_t;

    disp_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] t, input logic [3:0] o,
                        input logic [31:0] a, input logic [31:0] b);
        disp_t e;
        e.tag = t; e.op = o; e.a = a; e.b = b;
        exp_q.push_back(e);
    endtask

    // Monitor: each completed handshake is compared with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && fu_valid && fu_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R8", "unexpected dispatch tag", {28'd0, fu_tag}, 32'd0);
            end else begin
                disp_t e;
                e = exp_q.pop_front();
                check(fu_tag == e.tag, "R7", "dispatch tag", {28'd0, fu_tag}, {28'd0, e.tag});
                check(fu_op == e.op, "R10", "dispatch op", {28'd0, fu_op}, {28'd0, e.op});
                check(fu_a == e.a, "R4", "operand a", fu_a, e.a);
                check(fu_b == e.b, "R4", "operand b", fu_b, e.b);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [3:0] op,
                         input logic ar, input logic [31:0] av, input logic [3:0] at,
                         input logic br, input logic [31:0] bv, input logic [3:0] bt,
                         input logic [3:0] exp_tag);
        issue_valid = 1'b1; issue_op = op;
        issue_a_real = ar; issue_a_val = av; issue_a_tag = at;
        issue_b_real = br; issue_b_val = bv; issue_b_tag = bt;
        #2;
        check(issue_tag == exp_tag, "R2", "issue_tag", {28'd0, issue_tag}, {28'd0, exp_tag});
        check(!issue_stall, "R3", "stall on issue", {31'd0, issue_stall}, 32'd0);
        tick(1);
        issue_valid = 1'b0;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [31:0] d);
        cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
        tick(1);
        cdb_valid = 1'b0;
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 5000 && !done; wd++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        check(!issue_stall, "R1", "stall after reset", {31'd0, issue_stall}, 32'd0);
        check(!fu_valid, "R1", "fu_valid after reset", {31'd0, fu_valid}, 32'd0);
        tick(1);

        // B: out-of-order dispatch, tag match/mismatch (R2 R4 R6 R7 R10)
        fu_ready = 1'b0;
        issue(4'd1, 1'b1, 32'd10, 4'd0, 1'b0, 32'd0, 4'd9, 4'd4);
        issue(4'd2, 1'b1, 32'd3, 4'd0, 1'b1, 32'd4, 4'd0, 4'd5);
        #2;
        check(fu_valid && fu_tag == 4'd5, "R7", "younger ready slot offered",
              {28'd0, fu_tag}, 32'd5);
        push(4'd5, 4'd2, 32'd3, 32'd4);
        fu_ready = 1'b1;
        tick(1);
        bcast(4'd8, 32'd55);
        #2;
        check(!fu_valid, "R4", "mismatched tag ignored", {31'd0, fu_valid}, 32'd0);
        push(4'd4, 4'd1, 32'd10, 32'd77);
        bcast(4'd9, 32'd77);
        #2;
        check(fu_valid && fu_tag == 4'd4, "R6", "offer after capture",
              {28'd0, fu_tag}, 32'd4);
        tick(1);
        bcast(4'd5, 32'd0);
        bcast(4'd4, 32'd0);

        // C: same-cycle wakeup on issue (R5)
        push(4'd4, 4'd3, 32'd123, 32'd1);
        cdb_valid = 1'b1; cdb_tag = 4'd9; cdb_data = 32'd123;
        issue(4'd3, 1'b0, 32'd0, 4'd9, 1'b1, 32'd1, 4'd0, 4'd4);
        cdb_valid = 1'b0;
        #2;
        check(fu_valid && fu_tag == 4'd4, "R5", "same-cycle capture ready",
              {28'd0, fu_tag}, 32'd4);
        tick(2);
        bcast(4'd4, 32'd0);

        // D: full array, stall, dropped issue, hold, free (R3 R8 R9)
        fu_ready = 1'b0;
        for (int i = 0; i < 4; i++)
            issue(4'(4 + i), 1'b1, 32'(i * 10), 4'd0, 1'b0, 32'd0, 4'd12, 4'(4 + i));
        #2;
        check(issue_stall, "R3", "stall when full", {31'd0, issue_stall}, 32'd1);
        issue_valid = 1'b1; issue_op = 4'd7;
        issue_a_real = 1'b1; issue_b_real = 1'b1;
        tick(2);
        issue_valid = 1'b0;
        #2;
        check(!fu_valid, "R3", "dropped issue not offered", {31'd0, fu_valid}, 32'd0);
        for (int i = 0; i < 4; i++) push(4'(4 + i), 4'(4 + i), 32'(i * 10), 32'd5);
        bcast(4'd12, 32'd5);
        #2;
        check(fu_valid && fu_tag == 4'd4, "R8", "offer presented", {28'd0, fu_tag}, 32'd4);
        tick(1);
        #2;
        check(fu_valid && fu_tag == 4'd4, "R8", "offer held", {28'd0, fu_tag}, 32'd4);
        fu_ready = 1'b1;
        tick(4);
        #2;
        check(!fu_valid, "R8", "no re-offer", {31'd0, fu_valid}, 32'd0);
        check(issue_stall, "R9", "dispatched slots still held", {31'd0, issue_stall}, 32'd1);
        bcast(4'd6, 32'd0);
        #2;
        check(!issue_stall, "R9", "stall drops after own tag", {31'd0, issue_stall}, 32'd0);
        check(issue_tag == 4'd6, "R9", "freed slot offered to issue",
              {28'd0, issue_tag}, 32'd6);
        bcast(4'd4, 32'd0);
        bcast(4'd5, 32'd0);
        bcast(4'd7, 32'd0);

        // E: age beats slot index (R7)
        push(4'd4, 4'd8, 32'd1, 32'd2);
        issue(4'd8, 1'b1, 32'd1, 4'd0, 1'b1, 32'd2, 4'd0, 4'd4);
        issue(4'd9, 1'b0, 32'd0, 4'd13, 1'b1, 32'd3, 4'd0, 4'd5);
        issue(4'd10, 1'b0, 32'd0, 4'd13, 1'b1, 32'd4, 4'd0, 4'd6);
        bcast(4'd4, 32'd0);
        fu_ready = 1'b0;
        issue(4'd11, 1'b0, 32'd0, 4'd13, 1'b1, 32'd6, 4'd0, 4'd4);
        push(4'd5, 4'd9, 32'd70, 32'd3);
        push(4'd6, 4'd10, 32'd70, 32'd4);
        push(4'd4, 4'd11, 32'd70, 32'd6);
        bcast(4'd13, 32'd70);
        fu_ready = 1'b1;
        tick(5);
        #2;
        check(exp_q.size() == 0, "R7", "all expected dispatches seen",
              32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule